// File: doc/BRIEF.md
# Cluster Bus Coordinator

This block sits beside a shared system bus that links two to four processors directly. It decides which processor owns the bus. Each processor has its own request line and its own release line, and ownership is shown on a one-hot grant vector. Only the processor holding the grant may issue commands. Each accepted command is translated into the coherence action that the other processors must take. That action is broadcast, one cycle later, to every processor except the owner.

Arbitration is round-robin. The search starts at the processor after the most recent owner. A grant stays in place until its owner raises release. One dead cycle always separates two ownerships, so a new owner never overlaps the old one.

The command input is a valid/ready stream. `cmd_ready` is high while any grant is held. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. Any other command cycle is dropped and is not held over. The external command output has no back-pressure: observing processors must take it in the cycle it is valid. Some command codes are write-like or evict-like and cause no external action, so no valid is raised for them.

Top module: `cluster_bus_coord`

## Requirements
- R1: At most one bit of `gnt` is set in any cycle, and `gnt` is zero after reset.
- R2: A grant is only given to a processor whose request was high in the idle cycle before it. With no requests, `gnt` stays zero.
- R3: When idle, the grant goes to the first requester found by searching upward, with wrap-around, from the index after the last owner. After reset the search starts at processor 0.
- R4: A grant is held unchanged until its owner's `rel` bit is high. A release raised by a processor that does not own the bus has no effect.
- R5: In the cycle after the owner's release, `gnt` is zero. The next grant appears no earlier than the cycle after that.
- R6: `cmd_ready` is high exactly while a grant is held. A command offered while no grant is held produces no external command.
- R7: Command code 0 (coherent block read, shared) gives external code 0 (shared intervention). Command code 1 (coherent block read, exclusive) gives external code 1 (exclusive intervention).
- R8: Command code 2 (noncoherent block read) and command code 3 (word or partial read) both give external code 2 (allocate a request number).
- R9: Command code 6 (upgrade) gives external code 3 (invalidate).
- R10: Command code 4 (block write), code 5 (word or partial write) and code 7 (eliminate) raise no `ext_valid` bit.
- R11: For a forwarded command, `ext_valid` has every processor bit set except the owner's bit.
- R12: `ext_valid` is high only in the cycle right after an accepted forwarded command, and zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_PROC | Per-processor bus request |
| rel | input | NUM_PROC | Per-processor bus release pulse |
| cmd_valid | input | 1 | Owner's command is valid |
| cmd_ready | output | 1 | Command accepted (a grant is held) |
| cmd_code | input | 3 | Owner's command code |
| gnt | output | NUM_PROC | One-hot bus grant |
| ext_valid | output | NUM_PROC | Per-processor external command strobe |
| ext_cmd | output | 2 | External command code |

## Verification
The bench targets these corner cases:
- Search wrap-around from the highest index back to 0. An arbiter that restarts at index 0 every time would hand the bus to the wrong processor.
- Release pulses from processors that do not own the bus. A design that ORs all release bits would drop the grant early.
- A command offered during the idle gap after a release. A design that accepts it would broadcast a command with no owner.
- All eight command codes, checked against the fixed mapping, with the owner's own bit checked in `ext_valid`. A wrong mapping shows up as a wrong code, and a bad mask shows up as the owner seeing its own request.
- Long random traffic, compared every cycle against a behavioural model. This catches off-by-one timing in the grant and the broadcast.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [2:0] {
    MREQ_RD_SHARED  = 3'd0,
    MREQ_RD_EXCL    = 3'd1,
    MREQ_RD_NC_BLK  = 3'd2,
    MREQ_RD_WORD    = 3'd3,
    MREQ_WR_BLK     = 3'd4,
    MREQ_WR_WORD    = 3'd5,
    MREQ_UPGRADE    = 3'd6,
    MREQ_ELIMINATE  = 3'd7
  } mreq_e;

  typedef enum logic [1:0] {
    XCMD_INTV_SHARED = 2'd0,
    XCMD_INTV_EXCL   = 2'd1,
    XCMD_ALLOC_NUM   = 2'd2,
    XCMD_INVALIDATE  = 2'd3
  } xcmd_e;

  typedef struct packed {
    logic  fwd;
    xcmd_e op;
  } xlate_t;

endpackage

// File: rtl/cbc_rr_arbiter.sv
module cbc_rr_arbiter #(
  parameter int NUM_PROC = 4,
  localparam int IDX_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROC-1:0] req,
  input  logic [NUM_PROC-1:0] rel,
  output logic [NUM_PROC-1:0] gnt,
  output logic                busy
);

  logic             busy_q;
  logic [IDX_W-1:0] owner_q;
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;
  logic             owner_rel;

  // Round-robin search starting after the last owner
  always_comb begin
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int off = 1; off <= NUM_PROC; off++) begin
      int cand;
      cand = (int'(owner_q) + off) % NUM_PROC;
      if (!pick_hit && req[cand]) begin
        pick_hit = 1'b1;
        pick_idx = IDX_W'(cand);
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_PROC; i++) begin : g_gnt
      assign gnt[i] = busy_q && (owner_q == IDX_W'(i));
    end
  endgenerate

  assign owner_rel = |(rel & gnt);
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= IDX_W'(NUM_PROC - 1);
    end else if (busy_q) begin
      if (owner_rel) busy_q <= 1'b0;
    end else if (pick_hit) begin
      busy_q  <= 1'b1;
      owner_q <= pick_idx;
    end
  end

endmodule

// File: rtl/cbc_cmd_xlate.sv
module cbc_cmd_xlate
  import cbc_pkg::*;
(
  input  logic [2:0] code,
  output xlate_t     xl
);

  mreq_e kind;
  assign kind = mreq_e'(code);

  always_comb begin
    xl.fwd = 1'b0;
    xl.op  = XCMD_INTV_SHARED;
    unique case (kind)
      MREQ_RD_SHARED: begin xl.fwd = 1'b1; xl.op = XCMD_INTV_SHARED; end
      MREQ_RD_EXCL:   begin xl.fwd = 1'b1; xl.op = XCMD_INTV_EXCL;   end
      MREQ_RD_NC_BLK,
      MREQ_RD_WORD:   begin xl.fwd = 1'b1; xl.op = XCMD_ALLOC_NUM;   end
      MREQ_UPGRADE:   begin xl.fwd = 1'b1; xl.op = XCMD_INVALIDATE;  end
      MREQ_WR_BLK,
      MREQ_WR_WORD,
      MREQ_ELIMINATE: begin xl.fwd = 1'b0; xl.op = XCMD_INTV_SHARED; end
      default:        begin xl.fwd = 1'b0; xl.op = XCMD_INTV_SHARED; end
    endcase
  end

endmodule

// File: rtl/cbc_ext_bcast.sv
module cbc_ext_bcast
  import cbc_pkg::*;
#(
  parameter int NUM_PROC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  xlate_t              xl,
  input  logic [NUM_PROC-1:0] owner_oh,
  output logic [NUM_PROC-1:0] ext_valid,
  output logic [1:0]          ext_cmd
);

  logic send;
  assign send = fire && xl.fwd;

  generate
    for (genvar i = 0; i < NUM_PROC; i++) begin : g_slave
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_valid[i] <= 1'b0;
        else        ext_valid[i] <= send && !owner_oh[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ext_cmd <= '0;
    else if (send) ext_cmd <= xl.op;
  end

endmodule

// File: rtl/cluster_bus_coord.sv
module cluster_bus_coord
  import cbc_pkg::*;
#(
  parameter int NUM_PROC = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROC-1:0] req,
  input  logic [NUM_PROC-1:0] rel,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_code,
  output logic [NUM_PROC-1:0] gnt,
  output logic [NUM_PROC-1:0] ext_valid,
  output logic [1:0]          ext_cmd
);

  logic   busy;
  logic   fire;
  xlate_t xl;

  cbc_rr_arbiter #(.NUM_PROC(NUM_PROC)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .rel   (rel),
    .gnt   (gnt),
    .busy  (busy)
  );

  cbc_cmd_xlate u_xlate (
    .code (cmd_code),
    .xl   (xl)
  );

  assign cmd_ready = busy;
  assign fire      = cmd_valid && busy;

  cbc_ext_bcast #(.NUM_PROC(NUM_PROC)) u_bcast (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .xl        (xl),
    .owner_oh  (gnt),
    .ext_valid (ext_valid),
    .ext_cmd   (ext_cmd)
  );

endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int NUM_PROC = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PROC-1:0] req,
  input logic [NUM_PROC-1:0] rel,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [2:0]          cmd_code,
  input logic [NUM_PROC-1:0] gnt,
  input logic [NUM_PROC-1:0] ext_valid,
  input logic [1:0]          ext_cmd
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R1
  AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && req == '0) |=> gnt == '0); // R2
  AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> (gnt == '0 || (gnt & $past(req)) != '0)); // R2
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (rel & gnt) == '0) |=> gnt == $past(gnt)); // R4
  AST_GAP_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel & gnt) != '0) |=> gnt == '0); // R5
  AST_UPGRADE_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_code == 3'd6) |=> (ext_valid != '0 && ext_cmd == 2'd3)); // R9
  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_code == 3'd4 || cmd_code == 3'd5 || cmd_code == 3'd7)) |=> ext_valid == '0); // R10
  AST_NOT_TO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (ext_valid & $past(gnt)) == '0); // R11
  AST_QUIET_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ext_valid == '0); // R12

endmodule

bind cluster_bus_coord cbc_checker #(.NUM_PROC(NUM_PROC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .rel       (rel),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .gnt       (gnt),
  .ext_valid (ext_valid),
  .ext_cmd   (ext_cmd)
);

// File: tb/cluster_bus_coord_tb.sv
module cluster_bus_coord_tb;

  localparam int  N          = 4;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] rel = '0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_code = '0;
  logic         cmd_ready;
  logic [N-1:0] gnt;
  logic [N-1:0] ext_valid;
  logic [1:0]   ext_cmd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_bus_coord #(.NUM_PROC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .rel(rel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .gnt(gnt), .ext_valid(ext_valid), .ext_cmd(ext_cmd)
  );

  // ---------------- reference model ----------------
  int           m_own  = -1;
  int           m_last = N - 1;
  logic [N-1:0] m_ev   = '0;
  logic [1:0]   m_ec   = '0;

  function automatic bit ref_fwd(input logic [2:0] c);
    return !(c == 3'd4 || c == 3'd5 || c == 3'd7);
  endfunction

  function automatic logic [1:0] ref_op(input logic [2:0] c);
    case (c)
      3'd0:       return 2'd0;
      3'd1:       return 2'd1;
      3'd2, 3'd3: return 2'd2;
      3'd6:       return 2'd3;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic [N-1:0] ref_gnt();
    if (m_own < 0) return '0;
    return N'(1) << m_own;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = -1; m_last = N - 1; m_ev = '0; m_ec = '0;
    end else begin
      if (cmd_valid && m_own >= 0 && ref_fwd(cmd_code)) begin
        m_ev = ~(N'(1) << m_own);
        m_ec = ref_op(cmd_code);
      end else begin
        m_ev = '0;
      end
      if (m_own >= 0) begin
        if (rel[m_own]) m_own = -1;
      end else begin
        for (int off = 1; off <= N; off++) begin
          int cand;
          cand = (m_last + off) % N;
          if (m_own < 0 && req[cand]) begin
            m_own = cand; m_last = cand;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(gnt == ref_gnt(), "R1 R2 R3 R4 R5 grant", gnt, ref_gnt());
      chk(cmd_ready == (m_own >= 0), "R6 ready", cmd_ready, (m_own >= 0));
      chk(ext_valid == m_ev, "R11 R12 ext_valid", ext_valid, m_ev);
      if (m_ev != '0) chk(ext_cmd == m_ec, "R7 R8 R9 ext_cmd", ext_cmd, m_ec);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(gnt == '0, "R1 reset gnt", gnt, 0);
    chk(cmd_ready == 1'b0, "R6 reset ready", cmd_ready, 0);
    chk(ext_valid == '0, "R12 reset ext_valid", ext_valid, 0);

    req = '1;
    @(negedge clk);
    chk(gnt == 4'b0001, "R3 first grant to P0", gnt, 4'b0001);

    for (int c = 0; c < 8; c++) begin
      cmd_valid = 1'b1; cmd_code = 3'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      case (c)
        0, 1:    tag = "R7 intervention";
        2, 3:    tag = "R8 allocate";
        6:       tag = "R9 invalidate";
        default: tag = "R10 no-op";
      endcase
      if (ref_fwd(3'(c))) begin
        chk(ext_valid == 4'b1110, {tag, " R11 mask"}, ext_valid, 4'b1110);
        chk(ext_cmd == ref_op(3'(c)), tag, ext_cmd, ref_op(3'(c)));
      end else begin
        chk(ext_valid == '0, tag, ext_valid, 0);
      end
    end

    rel = 4'b0100;
    @(negedge clk); rel = '0;
    chk(gnt == 4'b0001, "R4 foreign release ignored", gnt, 4'b0001);

    rel = 4'b0001;
    @(negedge clk); rel = '0;
    chk(gnt == '0, "R5 idle after release", gnt, 0);
    cmd_valid = 1'b1; cmd_code = 3'd0;
    @(negedge clk); cmd_valid = 1'b0;
    chk(ext_valid == '0, "R6 command in gap dropped", ext_valid, 0);
    chk(gnt == 4'b0010, "R3 next after P0", gnt, 4'b0010);

    req = 4'b1001; rel = 4'b0010;
    @(negedge clk); rel = '0;
    @(negedge clk);
    chk(gnt == 4'b1000, "R3 skip to P3", gnt, 4'b1000);

    req = 4'b0001; rel = 4'b1000;
    @(negedge clk); rel = '0;
    @(negedge clk);
    chk(gnt == 4'b0001, "R3 wrap to P0", gnt, 4'b0001);

    req = '0; rel = 4'b0001;
    @(negedge clk); rel = '0;
    @(negedge clk);
    chk(gnt == '0, "R2 no request no grant", gnt, 0);
    @(negedge clk);
    chk(gnt == '0, "R2 still idle", gnt, 0);

    for (int i = 0; i < 4000; i++) begin
      req       = N'($urandom);
      rel       = (($urandom % 4) == 0) ? N'($urandom) : '0;
      cmd_valid = 1'($urandom);
      cmd_code  = 3'($urandom);
      @(negedge clk);
    end
    req = '0; rel = '0; cmd_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule